// File: doc/BRIEF.md
# Capability Control Register Set

This block holds three capability control registers, one for each privilege level (user, supervisor and machine), behind a single CSR read/write port. A request gives a 12-bit CSR address, the current privilege and an optional write. The block reports at once whether that address names a register that exists in this configuration and can be reached from that privilege. It returns the register's present contents and the legalised value a write would leave behind.

Writes are legalised so that only defined fields change. The supervisor and machine registers each carry two generation bits: one for user pages and one for system pages. The user register has no writable field. Two status bits (dirty and enable) read as one at all times. The two global generation bits that a load-permission decoder compares against are exported continuously. They come from the supervisor register when supervisor mode is built in, and from the machine register otherwise.

Top module: `cap_ctl_regs`

## Requirements
- R1: The user register sits at CSR address 0x8C0, the supervisor register at 0x9C0 and the machine register at 0xBC0. Any other address reports undefined, and both `csr_rdata` and `csr_wvalue` are zero for it.
- R2: The user register is defined at every privilege when `HAS_USER` is 1, and never when it is 0.
- R3: The supervisor register is defined only when `HAS_SUPER` is 1 and `csr_priv` is machine (2'b11) or supervisor (2'b01).
- R4: The machine register is defined only when `csr_priv` is machine (2'b11). User is 2'b00; 2'b10 counts as neither supervisor nor machine.
- R5: The field layout is user-page generation at bit 3, system-page generation at bit 2, dirty at bit 1 and enable at bit 0. Dirty and enable always read 1, whatever was written.
- R6: A write to a defined supervisor or machine register copies bits 3 and 2 of the write data into the generation bits on the next clock edge. Bits above bit 3 keep their value, which is zero from reset.
- R7: A write to the user register leaves it unchanged; it always reads 0x3.
- R8: `csr_wvalue` shows in the same cycle the legalised value the addressed register would take from `csr_wdata`. A write to an undefined address, or at a privilege that cannot reach the register, changes no register.
- R9: `gen_user_page` and `gen_sys_page` follow bits 3 and 2 of the supervisor register when `HAS_SUPER` is 1, and of the machine register otherwise.
- R10: Reset clears every generation bit, so each register reads 0x3 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the request |
| csr_priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_defined | output | 1 | Address names a register reachable at this privilege |
| csr_rdata | output | XLEN | Present value of the addressed register, zero if undefined |
| csr_wvalue | output | XLEN | Legalised value a write of csr_wdata would leave, zero if undefined |
| gen_user_page | output | 1 | Global generation bit for user pages |
| gen_sys_page | output | 1 | Global generation bit for system pages |

## Verification
A generation bit that holds a wrong value shows on `gen_user_page` or `gen_sys_page` on the cycle after the faulty write. It also shows on the very next read of that register. A wrong address or privilege decode shows in the same cycle on `csr_defined` and as a zero or non-zero `csr_rdata`. A write that leaks through a blocked decode appears one cycle later in the exported bits or in a later read. A second instance built without supervisor mode shows that the exported bits switch to the machine register.

// File: rtl/cap_ctl_pkg.sv
package cap_ctl_pkg;

    localparam logic [11:0] ADDR_USER  = 12'h8C0;
    localparam logic [11:0] ADDR_SUPER = 12'h9C0;
    localparam logic [11:0] ADDR_MACH  = 12'hBC0;

    localparam int BIT_UGEN  = 3;
    localparam int BIT_SGEN  = 2;
    localparam int BIT_DIRTY = 1;
    localparam int BIT_EN    = 0;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef struct packed {
        logic user;
        logic super_r;
        logic mach;
    } reg_sel_t;

endpackage

// File: rtl/cap_ctl_decode.sv
module cap_ctl_decode
    import cap_ctl_pkg::*;
#(
    parameter bit HAS_USER  = 1'b1,
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    output reg_sel_t    sel,
    output logic        defined
);

    priv_e cur_priv;
    logic  priv_ms;
    logic  priv_m;

    always_comb begin
        cur_priv = priv_e'(priv);
        priv_m   = (cur_priv == PRIV_MACH);
        priv_ms  = (cur_priv == PRIV_MACH) || (cur_priv == PRIV_SUPER);
    end

    always_comb begin
        sel         = '0;
        sel.user    = HAS_USER  && (addr == ADDR_USER);
        sel.super_r = HAS_SUPER && priv_ms && (addr == ADDR_SUPER);
        sel.mach    = priv_m && (addr == ADDR_MACH);
        defined     = sel.user || sel.super_r || sel.mach;
    end

endmodule

// File: rtl/cap_ctl_reg.sv
module cap_ctl_reg
    import cap_ctl_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter bit GEN_WRITABLE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] q,
    output logic [XLEN-1:0] q_legal
);

    localparam logic [XLEN-1:0] RST_VAL = {{(XLEN-2){1'b0}}, 2'b11};

    generate
        if (GEN_WRITABLE) begin : g_gen_wr
            always_comb begin
                q_legal            = q;
                q_legal[BIT_UGEN]  = wdata[BIT_UGEN];
                q_legal[BIT_SGEN]  = wdata[BIT_SGEN];
                q_legal[BIT_DIRTY] = 1'b1;
                q_legal[BIT_EN]    = 1'b1;
            end
        end else begin : g_gen_ro
            logic unused_wdata;
            assign unused_wdata = ^wdata;
            always_comb begin
                q_legal            = q;
                q_legal[BIT_DIRTY] = 1'b1;
                q_legal[BIT_EN]    = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else if (we) q <= q_legal;
    end

    AST_STATUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        q[BIT_DIRTY] && q[BIT_EN]); // R5

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        q[XLEN-1:BIT_UGEN+1] == '0); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R8

    generate
        if (GEN_WRITABLE) begin : g_ast_wr
            AST_GEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> q[BIT_UGEN:BIT_SGEN] == $past(wdata[BIT_UGEN:BIT_SGEN])); // R6
        end else begin : g_ast_ro
            AST_USER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> $stable(q)); // R7
        end
    endgenerate

endmodule

// File: rtl/cap_ctl_gen_sel.sv
module cap_ctl_gen_sel
    import cap_ctl_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic [XLEN-1:0] super_q,
    input  logic [XLEN-1:0] mach_q,
    output logic            gen_user,
    output logic            gen_sys
);

    logic unused_bits;

    generate
        if (HAS_SUPER) begin : g_from_super
            assign gen_user    = super_q[BIT_UGEN];
            assign gen_sys     = super_q[BIT_SGEN];
            assign unused_bits = ^mach_q;
        end else begin : g_from_mach
            assign gen_user    = mach_q[BIT_UGEN];
            assign gen_sys     = mach_q[BIT_SGEN];
            assign unused_bits = ^super_q;
        end
    endgenerate

endmodule

// File: rtl/cap_ctl_regs.sv
module cap_ctl_regs
    import cap_ctl_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter bit HAS_USER  = 1'b1,
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_priv,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic            csr_defined,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] csr_wvalue,
    output logic            gen_user_page,
    output logic            gen_sys_page
);

    localparam int NREG = 3;

    reg_sel_t        sel;
    logic [NREG-1:0] sel_vec;
    logic [XLEN-1:0] q_arr     [NREG];
    logic [XLEN-1:0] legal_arr [NREG];

    assign sel_vec = {sel.mach, sel.super_r, sel.user};

    cap_ctl_decode #(
        .HAS_USER  (HAS_USER),
        .HAS_SUPER (HAS_SUPER)
    ) u_decode (
        .addr    (csr_addr),
        .priv    (csr_priv),
        .sel     (sel),
        .defined (csr_defined)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            cap_ctl_reg #(
                .XLEN         (XLEN),
                .GEN_WRITABLE (gi != 0)
            ) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (csr_we && sel_vec[gi]),
                .wdata   (csr_wdata),
                .q       (q_arr[gi]),
                .q_legal (legal_arr[gi])
            );
        end
    endgenerate

    always_comb begin
        csr_rdata  = '0;
        csr_wvalue = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel_vec[i]) begin
                csr_rdata  = q_arr[i];
                csr_wvalue = legal_arr[i];
            end
        end
    end

    cap_ctl_gen_sel #(
        .XLEN      (XLEN),
        .HAS_SUPER (HAS_SUPER)
    ) u_gen_sel (
        .super_q  (q_arr[1]),
        .mach_q   (q_arr[2]),
        .gen_user (gen_user_page),
        .gen_sys  (gen_sys_page)
    );

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec)); // R1

    AST_MACH_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        sel.mach |-> csr_priv == 2'b11); // R4

    AST_SUPER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        sel.super_r |-> (csr_priv == 2'b11 || csr_priv == 2'b01)); // R3

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_defined |-> (csr_rdata == '0 && csr_wvalue == '0)); // R1

    AST_EXPORT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_defined && csr_addr == (HAS_SUPER ? ADDR_SUPER : ADDR_MACH))
        |=> {gen_user_page, gen_sys_page} == $past(csr_wdata[BIT_UGEN:BIT_SGEN])); // R9

endmodule

// File: tb/cap_ctl_regs_tb.sv
module cap_ctl_regs_tb;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     addr = '0;
    logic [1:0]      priv = '0;
    logic            we = 1'b0;
    logic [XLEN-1:0] wdata = '0;

    logic            def_a, def_b;
    logic [XLEN-1:0] rd_a, rd_b, wv_a, wv_b;
    logic            gu_a, gs_a, gu_b, gs_b;

    int errors = 0;
    int checks = 0;

    // Model state: generation pair {user-page, system-page} per register
    logic [1:0] a_s, a_m, b_m;

    always #5 clk = ~clk;

    cap_ctl_regs #(.XLEN(XLEN), .HAS_USER(1'b1), .HAS_SUPER(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_priv(priv), .csr_we(we),
        .csr_wdata(wdata), .csr_defined(def_a), .csr_rdata(rd_a), .csr_wvalue(wv_a),
        .gen_user_page(gu_a), .gen_sys_page(gs_a));

    cap_ctl_regs #(.XLEN(XLEN), .HAS_USER(1'b1), .HAS_SUPER(1'b0)) u_dut_nosup (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_priv(priv), .csr_we(we),
        .csr_wdata(wdata), .csr_defined(def_b), .csr_rdata(rd_b), .csr_wvalue(wv_b),
        .gen_user_page(gu_b), .gen_sys_page(gs_b));

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (addr=%0h priv=%0d we=%0b)",
                     req, act, exp, addr, priv, we);
        end
    endtask

    function automatic logic [XLEN-1:0] val_of(input logic [1:0] g);
        return {{(XLEN-4){1'b0}}, g, 2'b11};
    endfunction

    // Drive one request, check same-cycle outputs, then apply model after edge
    task automatic op(input logic [11:0] a, input logic [1:0] p, input logic w,
                      input logic [XLEN-1:0] d);
        logic            ed_a, ed_b, is_m, is_ms;
        logic [XLEN-1:0] er_a, er_b, ew_a, ew_b;
        logic [1:0]      ng;
        @(negedge clk);
        addr = a; priv = p; we = w; wdata = d;
        #2;
        is_m  = (p == 2'b11);
        is_ms = (p == 2'b11) || (p == 2'b01);
        ng    = d[3:2];
        ed_a = 1'b0; er_a = '0; ew_a = '0;
        ed_b = 1'b0; er_b = '0; ew_b = '0;
        if (a == 12'h8C0) begin                       // R2, R7
            ed_a = 1'b1; er_a = val_of(2'b00); ew_a = val_of(2'b00);
            ed_b = 1'b1; er_b = val_of(2'b00); ew_b = val_of(2'b00);
        end else if (a == 12'h9C0 && is_ms) begin     // R3
            ed_a = 1'b1; er_a = val_of(a_s); ew_a = val_of(ng);
        end else if (a == 12'hBC0 && is_m) begin      // R4
            ed_a = 1'b1; er_a = val_of(a_m); ew_a = val_of(ng);
            ed_b = 1'b1; er_b = val_of(b_m); ew_b = val_of(ng);
        end
        chk("R1/R2/R3/R4 defined", {63'd0, def_a}, {63'd0, ed_a});
        chk("R3/R4 defined nosup", {63'd0, def_b}, {63'd0, ed_b});
        chk("R1/R5 rdata", rd_a, er_a);
        chk("R1/R5 rdata nosup", rd_b, er_b);
        chk("R8 wvalue", wv_a, ew_a);
        chk("R8 wvalue nosup", wv_b, ew_b);
        chk("R9 export", {62'd0, gu_a, gs_a}, {62'd0, a_s});
        chk("R9 export nosup", {62'd0, gu_b, gs_b}, {62'd0, b_m});
        @(posedge clk);
        if (w) begin
            if (a == 12'h9C0 && is_ms) a_s = ng;          // R6
            if (a == 12'hBC0 && is_m) begin a_m = ng; b_m = ng; end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0;
        a_s = 2'b00; a_m = 2'b00; b_m = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [11:0] addrs [5];
        addrs = '{12'h8C0, 12'h9C0, 12'hBC0, 12'h8C1, 12'h3C0};
        do_reset();
        // R10: reset state
        op(12'hBC0, 2'b11, 1'b0, '0);
        op(12'h9C0, 2'b01, 1'b0, '0);
        // R6: machine write of all ones, upper bits untouched
        op(12'hBC0, 2'b11, 1'b1, '1);
        op(12'hBC0, 2'b11, 1'b0, '0);
        // R6: supervisor write, only system-page gen
        op(12'h9C0, 2'b01, 1'b1, 64'h4);
        op(12'h9C0, 2'b11, 1'b0, '0);
        // R3: supervisor register from user privilege is blocked
        op(12'h9C0, 2'b00, 1'b1, 64'h8);
        op(12'h9C0, 2'b10, 1'b1, 64'h8);
        // R4: machine register from supervisor privilege is blocked
        op(12'hBC0, 2'b01, 1'b1, 64'h0);
        op(12'hBC0, 2'b11, 1'b0, '0);
        // R7: user register writes ignored
        op(12'h8C0, 2'b00, 1'b1, '1);
        op(12'h8C0, 2'b11, 1'b0, '0);
        // R5: writing zeros keeps dirty/enable at one
        op(12'h9C0, 2'b11, 1'b1, 64'h0);
        op(12'h9C0, 2'b11, 1'b0, '0);
        // R1: neighbouring address undefined
        op(12'h8C1, 2'b11, 1'b1, '1);
        op(12'hBC0, 2'b11, 1'b1, 64'h8);
        // mixed patterns
        for (int i = 0; i < 400; i++) begin
            op(addrs[$urandom_range(0, 4)], 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), {$urandom, $urandom});
        end
        // R10: reset clears generation bits
        op(12'h9C0, 2'b11, 1'b1, 64'hC);
        op(12'hBC0, 2'b11, 1'b1, 64'hC);
        do_reset();
        op(12'hBC0, 2'b11, 1'b0, '0);
        op(12'h9C0, 2'b11, 1'b0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule